// File: doc/BRIEF.md
# Full-Duplex Synchronous Serial Port

This block exchanges one byte with a remote device over a clocked serial link: a single start command shifts the held transmit byte out on the data-out pin while the same number of clock edges shift a byte in from the data-in pin. Software-facing logic sees a parallel side made of a transmit byte with a write strobe, a received byte, two configuration bits, a start strobe, a busy flag, a one-cycle completion interrupt and a sticky error flag for writes that arrive too late.

The serial clock comes from one of two sources, selected per transfer. In internal mode the block drives the clock pin from a divider on the system clock. In external mode the pin is an input that is resynchronised and edge-detected. The bit order, most significant or least significant first, is likewise chosen per transfer and applies to both directions. A ready output tells the partner that the port is armed for an exchange.

Top module: `sync_serial_port`

## Requirements
- R1: After reset busy, readyOut, doneIrq and writeErr are 0, sclkOut and serOut are 1, and rxData is 0.
- R2: A start pulse while idle begins a transfer of the byte held for transmission, or of txData when txWrite is asserted in the same cycle; busy and readyOut rise on the next clock edge and fall on the edge that takes in the eighth bit.
- R3: sclkOut is high whenever no transfer is running; in internal mode it drives eight low half-periods of HALF_CYCLES system cycles each, separated by high half-periods of the same length. sclkOe is 1 in internal mode and 0 in external mode.
- R4: serOut changes only on a falling serial clock edge and serIn is sampled on a rising edge, so one byte leaves and one byte arrives in the same transfer.
- R5: With cfgLsbFirst = 1 bit 0 is sent first and the first bit received lands in rxData bit 0; with cfgLsbFirst = 0 bit 7 is sent first and the first bit received lands in rxData bit 7.
- R6: In external mode (cfgExtClk = 1) a level change on sclkIn is acted upon on the third system clock edge after it is sampled, so each sclkIn level must last at least four system cycles.
- R7: doneIrq is a single-cycle pulse, high for the cycle after the edge on which busy falls, and rxData holds the full received byte from that cycle on.
- R8: A txWrite while busy leaves the transmit byte unchanged and sets writeErr, which stays 1 until reset.
- R9: A start pulse while busy is ignored, and changes to cfgExtClk or cfgLsbFirst while busy take effect only at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgExtClk | input | 1 | 1 = serial clock taken from sclkIn, 0 = generated internally |
| cfgLsbFirst | input | 1 | 1 = least significant bit first, 0 = most significant bit first |
| txWrite | input | 1 | Write strobe for the transmit byte |
| txData | input | 8 | Transmit byte |
| start | input | 1 | Begin a transfer |
| rxData | output | 8 | Last received byte |
| busy | output | 1 | Transfer in progress |
| doneIrq | output | 1 | One-cycle completion interrupt request |
| writeErr | output | 1 | Sticky flag for a transmit write during a transfer |
| serIn | input | 1 | Serial data from the partner |
| serOut | output | 1 | Serial data to the partner |
| readyOut | output | 1 | Port armed for an exchange |
| sclkIn | input | 1 | Serial clock pin, input side |
| sclkOut | output | 1 | Serial clock pin, output side |
| sclkOe | output | 1 | Output enable for the serial clock pin |

## Verification
With the default divider, a start seen at edge E0 makes busy and readyOut visible after E0; bit k appears on serOut after edge E(2k+1), is captured from serIn at edge E(2k+2), and doneIrq is visible only in the cycle after E16. In external mode every sclkIn change is driven at a falling system edge and its effect is visible after the third rising edge, so the bench holds each level for four cycles and reads serOut, doneIrq and busy at exactly that cycle. All inputs change and all outputs are read at the falling system edge, so every comparison lands one half-cycle after the register that produces it has settled.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  // Strobes from the sequencer to the shift datapath, all single-cycle.
  typedef struct packed {
    logic load;      // capture the transmit byte into the shifter
    logic shiftOut;  // falling serial edge: present next bit
    logic sampleIn;  // rising serial edge: take serIn
    logic finish;    // last bit taken: publish byte, raise interrupt
  } sspStrobes_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } sspState_e;

endpackage

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int WORD_BITS   = 8,
  parameter int HALF_CYCLES = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgExtClk,
  input  logic        cfgLsbFirst,
  input  logic        start,
  input  logic        sclkIn,
  output sspStrobes_t strb,
  output logic        busy,
  output logic        lsbMode,
  output logic        sclkOut,
  output logic        sclkOe
);

  localparam int CNT_W = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam int DIV_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_BITS - 1);

  sspState_e       stateQ;
  logic            extModeQ;
  logic            lsbModeQ;
  logic            sclkQ;
  logic [CNT_W-1:0] bitCntQ;
  logic [2:0]      syncQ;
  logic            tick;
  logic            loadEv;
  logic            fallEv;
  logic            riseEv;
  logic            lastEv;
  logic            running;

  assign running = (stateQ == ST_SHIFT);
  assign loadEv  = start && !running;

  // External clock: two synchroniser flops plus one history flop.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 3'b111;
    else       syncQ <= {syncQ[1:0], sclkIn};
  end

  // Half-period divider for the internal clock.
  generate
    if (HALF_CYCLES == 1) begin : g_noDiv
      assign tick = 1'b1;
    end else begin : g_div
      logic [DIV_W-1:0] divQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          divQ <= '0;
        end else if (loadEv || (running && divQ == '0)) begin
          divQ <= DIV_W'(HALF_CYCLES - 1);
        end else if (running) begin
          divQ <= divQ - 1'b1;
        end
      end
      assign tick = (divQ == '0);
    end
  endgenerate

  always_comb begin
    if (extModeQ) begin
      fallEv = running && syncQ[2] && !syncQ[1];
      riseEv = running && !syncQ[2] && syncQ[1];
    end else begin
      fallEv = running && tick && sclkQ;
      riseEv = running && tick && !sclkQ;
    end
    lastEv = riseEv && (bitCntQ == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      extModeQ <= 1'b0;
      lsbModeQ <= 1'b0;
      sclkQ    <= 1'b1;
      bitCntQ  <= '0;
    end else if (loadEv) begin
      stateQ   <= ST_SHIFT;
      extModeQ <= cfgExtClk;
      lsbModeQ <= cfgLsbFirst;
      sclkQ    <= 1'b1;
      bitCntQ  <= '0;
    end else if (running) begin
      if (!extModeQ && tick) sclkQ <= !sclkQ;
      if (riseEv)            bitCntQ <= bitCntQ + 1'b1;
      if (lastEv)            stateQ <= ST_IDLE;
    end
  end

  assign strb.load     = loadEv;
  assign strb.shiftOut = fallEv;
  assign strb.sampleIn = riseEv;
  assign strb.finish   = lastEv;

  assign busy    = running;
  assign lsbMode = lsbModeQ;
  assign sclkOut = sclkQ;
  assign sclkOe  = running ? !extModeQ : !cfgExtClk;

endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import ssp_pkg::*;
#(
  parameter int WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sspStrobes_t          strb,
  input  logic                 busy,
  input  logic                 lsbMode,
  input  logic                 txWrite,
  input  logic [WORD_BITS-1:0] txData,
  input  logic                 serIn,
  output logic                 serOut,
  output logic [WORD_BITS-1:0] rxData,
  output logic                 writeErr,
  output logic                 doneIrq
);

  logic [WORD_BITS-1:0] txHoldQ;
  logic [WORD_BITS-1:0] txShiftQ;
  logic [WORD_BITS-1:0] rxShiftQ;
  logic [WORD_BITS-1:0] rxNext;
  logic [WORD_BITS-1:0] loadValue;
  logic [WORD_BITS-1:0] txShifted;
  logic                 headBit;

  assign loadValue = txWrite ? txData : txHoldQ;

  always_comb begin
    if (lsbMode) begin
      headBit   = txShiftQ[0];
      txShifted = {1'b0, txShiftQ[WORD_BITS-1:1]};
      rxNext    = {serIn, rxShiftQ[WORD_BITS-1:1]};
    end else begin
      headBit   = txShiftQ[WORD_BITS-1];
      txShifted = {txShiftQ[WORD_BITS-2:0], 1'b0};
      rxNext    = {rxShiftQ[WORD_BITS-2:0], serIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHoldQ  <= '0;
      writeErr <= 1'b0;
    end else if (txWrite) begin
      if (busy) writeErr <= 1'b1;
      else      txHoldQ  <= txData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShiftQ <= '0;
      serOut   <= 1'b1;
    end else if (strb.load) begin
      txShiftQ <= loadValue;
    end else if (strb.shiftOut) begin
      serOut   <= headBit;
      txShiftQ <= txShifted;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShiftQ <= '0;
      rxData   <= '0;
      doneIrq  <= 1'b0;
    end else begin
      if (strb.sampleIn) rxShiftQ <= rxNext;
      if (strb.finish)   rxData   <= rxNext;
      doneIrq <= strb.finish;
    end
  end

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int WORD_BITS   = 8,
  parameter int HALF_CYCLES = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgExtClk,
  input  logic                 cfgLsbFirst,
  input  logic                 txWrite,
  input  logic [WORD_BITS-1:0] txData,
  input  logic                 start,
  output logic [WORD_BITS-1:0] rxData,
  output logic                 busy,
  output logic                 doneIrq,
  output logic                 writeErr,
  input  logic                 serIn,
  output logic                 serOut,
  output logic                 readyOut,
  input  logic                 sclkIn,
  output logic                 sclkOut,
  output logic                 sclkOe
);

  sspStrobes_t strb;
  logic        lsbMode;
  logic        busyInt;

  ssp_ctrl #(
    .WORD_BITS  (WORD_BITS),
    .HALF_CYCLES(HALF_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgExtClk  (cfgExtClk),
    .cfgLsbFirst(cfgLsbFirst),
    .start      (start),
    .sclkIn     (sclkIn),
    .strb       (strb),
    .busy       (busyInt),
    .lsbMode    (lsbMode),
    .sclkOut    (sclkOut),
    .sclkOe     (sclkOe)
  );

  ssp_datapath #(
    .WORD_BITS(WORD_BITS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .busy    (busyInt),
    .lsbMode (lsbMode),
    .txWrite (txWrite),
    .txData  (txData),
    .serIn   (serIn),
    .serOut  (serOut),
    .rxData  (rxData),
    .writeErr(writeErr),
    .doneIrq (doneIrq)
  );

  assign busy     = busyInt;
  assign readyOut = busyInt;

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic readyOut,
  input logic doneIrq,
  input logic writeErr,
  input logic txWrite,
  input logic serOut,
  input logic sclkOut,
  input logic sclkOe
);

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);  // R7

  AST_IRQ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> (!busy && $past(busy)));  // R7

  AST_READY_DROP_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readyOut) |-> doneIrq);  // R2

  AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sclkOut);  // R3

  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sclkOe && !$stable(serOut)) |-> $fell(sclkOut));  // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    writeErr |=> writeErr);  // R8

  AST_ERR_ON_LATE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && txWrite) |=> writeErr);  // R8

endmodule

bind sync_serial_port ssp_checker u_sspChecker (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .readyOut(readyOut),
  .doneIrq (doneIrq),
  .writeErr(writeErr),
  .txWrite (txWrite),
  .serOut  (serOut),
  .sclkOut (sclkOut),
  .sclkOe  (sclkOe)
);

// File: tb/test_sync_serial_port.sv
module test_sync_serial_port;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgExtClk = 1'b0;
  logic       cfgLsbFirst = 1'b0;
  logic       txWrite = 1'b0;
  logic [7:0] txData = 8'h00;
  logic       start = 1'b0;
  logic [7:0] rxData;
  logic       busy;
  logic       doneIrq;
  logic       writeErr;
  logic       serIn = 1'b0;
  logic       serOut;
  logic       readyOut;
  logic       sclkIn = 1'b1;
  logic       sclkOut;
  logic       sclkOe;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  sync_serial_port i_sync_serial_port (
    .clk(clk), .rstN(rstN), .cfgExtClk(cfgExtClk), .cfgLsbFirst(cfgLsbFirst),
    .txWrite(txWrite), .txData(txData), .start(start), .rxData(rxData),
    .busy(busy), .doneIrq(doneIrq), .writeErr(writeErr), .serIn(serIn),
    .serOut(serOut), .readyOut(readyOut), .sclkIn(sclkIn),
    .sclkOut(sclkOut), .sclkOe(sclkOe)
  );

  // {ext, lsbFirst, txByte, byteFromPartner}
  localparam logic [17:0] VECS [6] = '{
    {1'b0, 1'b0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 8'h01, 8'h80},
    {1'b1, 1'b0, 8'hF0, 8'h0F},
    {1'b1, 1'b1, 8'h96, 8'hE1},
    {1'b0, 1'b0, 8'hFF, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'hFF}
  };

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // mid: 0 none, 1 write during transfer, 2 start and config flip during transfer
  task automatic runXfer(input logic ext, input logic lsb, input logic [7:0] expTx,
                         input logic [7:0] rxIn, input logic doWrite, input int mid,
                         input string req);
    int   bitErr = 0;
    logic doneSeen = 1'b0;
    @(negedge clk);
    cfgExtClk = ext; cfgLsbFirst = lsb;
    txData = expTx; txWrite = doWrite; start = 1'b1;
    @(negedge clk);
    txWrite = 1'b0; start = 1'b0;
    check(busy && readyOut, "R2", "busy/ready after start", {busy, readyOut}, 2'b11);
    check(sclkOe == !ext, "R3", "clock output enable", sclkOe, !ext);
    for (int k = 0; k < 8; k++) begin
      logic outBit = lsb ? expTx[k] : expTx[7-k];
      logic inBit  = lsb ? rxIn[k]  : rxIn[7-k];
      if (ext) begin sclkIn = 1'b0; repeat (4) @(negedge clk); end
      else begin
        @(negedge clk);
        if (sclkOut !== 1'b0) bitErr++;
      end
      if (serOut !== outBit) bitErr++;
      serIn = inBit;
      if (k == 3 && mid == 1) begin txWrite = 1'b1; txData = ~expTx; end
      if (k == 3 && mid == 2) begin start = 1'b1; cfgLsbFirst = ~lsb; end
      if (ext) begin sclkIn = 1'b1; repeat (3) @(negedge clk); end
      else begin
        @(negedge clk);
        if (sclkOut !== 1'b1) bitErr++;
      end
      txWrite = 1'b0; start = 1'b0;
      if (k == 7) doneSeen = doneIrq;
      else if (busy !== 1'b1) bitErr++;
      if (ext) @(negedge clk);
    end
    check(bitErr == 0, ext ? "R6" : "R4", "serial bit stream errors", bitErr, 0);
    check(doneSeen, "R7", "doneIrq at completion", doneSeen, 1'b1);
    check(rxData == rxIn, "R5", "received byte", rxData, rxIn);
    check(!busy && !readyOut, "R2", "busy/ready after last bit", {busy, readyOut}, 2'b00);
    if (!ext) @(negedge clk);
    check(!doneIrq, "R7", "doneIrq one cycle only", doneIrq, 1'b0);
    check(sclkOut, "R3", "clock idles high", sclkOut, 1'b1);
    cfgLsbFirst = lsb;
    $display("%s transfer done: ext=%0d lsb=%0d tx=%0h", req, ext, lsb, expTx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !readyOut && !doneIrq && !writeErr, "R1", "flags in reset",
          {busy, readyOut, doneIrq, writeErr}, 0);
    check(sclkOut && serOut && rxData == 8'h00, "R1", "pins and rxData in reset",
          {sclkOut, serOut, rxData}, 10'h300);
    rstN = 1'b1;
    @(negedge clk);
    check(sclkOe == 1'b1, "R3", "oe in internal idle", sclkOe, 1'b1);
    cfgExtClk = 1'b1;
    @(negedge clk);
    check(sclkOe == 1'b0, "R3", "oe in external idle", sclkOe, 1'b0);

    // vector table: R4 R5 R6 R7 over both clock sources and orders
    for (int i = 0; i < 6; i++) begin
      runXfer(VECS[i][17], VECS[i][16], VECS[i][15:8], VECS[i][7:0], 1'b1, 0, "R5");
    end
    check(!writeErr, "R8", "no error after clean writes", writeErr, 1'b0);

    // R2: start without write sends the last held byte (00 from the table)
    runXfer(1'b0, 1'b0, 8'h00, 8'h5A, 1'b0, 0, "R2");

    // R8: write during a transfer is ignored and flags an error
    runXfer(1'b0, 1'b0, 8'hC3, 8'h5A, 1'b1, 1, "R8");
    check(writeErr, "R8", "error set by late write", writeErr, 1'b1);
    runXfer(1'b0, 1'b1, 8'hC3, 8'h81, 1'b0, 0, "R8");
    check(writeErr, "R8", "error stays set", writeErr, 1'b1);

    // R9: start and order change during a transfer have no effect on it
    runXfer(1'b0, 1'b0, 8'h3A, 8'hC5, 1'b1, 2, "R9");
    runXfer(1'b1, 1'b1, 8'h6E, 8'h27, 1'b1, 2, "R9");
    check(!busy, "R9", "no second transfer from ignored start", busy, 1'b0);

    // R1: reset clears the sticky error
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check(!writeErr && rxData == 8'h00, "R1", "reset clears error and rxData",
          {writeErr, rxData}, 0);
    rstN = 1'b1;
    @(negedge clk);
    finishRun();
  end

endmodule